// File: doc/BRIEF.md
# Interrupt Source Selector with Polarity Control

This block steers a pool of interrupt sources onto twelve CPU interrupt lines, numbered INT4 through INT15. The pool combines on-chip peripheral request levels with four external interrupt pins. Each CPU line has its own select field that picks one source from the pool. The chosen level is registered, and a rising edge on it produces a one-cycle pulse on that CPU line. The CPU's own enable, priority and vectoring logic sits downstream and is not part of this block.

Each external pin passes through a synchronizer. After that, a per-pin polarity bit can invert it before it reaches the selectors. With the bit clear, a low-to-high pin transition raises the interrupt. With the bit set, a high-to-low transition raises it. The inversion is applied ahead of the edge detector, so changing a polarity bit can itself produce an edge on every line that selects that pin. The same synchronized pins also drive DMA event outputs, and those outputs never see the inversion.

Software reaches the three registers through a simple 32-bit bus. Writes take effect at once and honour byte enables. Read data appears on the cycle after the read strobe.

Top module: `irq_selector`

## Requirements
- R1: Registers are decoded at word-aligned byte offsets: 0x0 holds the selects for INT10–INT15, 0x4 holds the selects for INT4–INT9, and 0x8 holds polarity. Any other offset, or any offset with address bits [1:0] nonzero, reads as 0 and ignores writes. Read data is presented in the cycle after the read strobe is sampled, and the read data port is 0 in any cycle that does not follow a read strobe.
- R2: Each select register holds six 5-bit fields at bits [4:0], [9:5], [14:10], [20:16], [25:21] and [30:26], assigned to ascending CPU lines starting with the lowest line of that register. All other bits read as 0.
- R3: After reset, CPU line INTn selects source index n−4 in every field, and all polarity bits are 0. Read back, offset 0x0 gives 0x2D4920E6 and offset 0x4 gives 0x14830820.
- R4: Polarity bits [3:0] control external pins 4–7 in that order, and each is read/write. Bits [31:4] read as 0 and ignore writes.
- R5: A write changes only the bytes whose byte-enable bit is set; bus_be_i[k] covers data bits [8k+7:8k].
- R6: Source index 0–3 is peripheral input 0–3, index 4–7 is external pin 4–7 after polarity, and index 8–15 is peripheral input 4–11. Select codes 16–31 drive a constant 0.
- R7: With polarity 0, a rising pin edge pulses every line that selects that pin. The pulse appears in the third cycle after the pin changes. A rising peripheral level pulses its lines in the first cycle after it changes.
- R8: With polarity 1, a falling pin edge raises the pulse, and a rising pin edge raises nothing.
- R9: Writing a polarity bit 0→1 while its pin is low, or 1→0 while its pin is high, pulses every CPU line that selects that pin.
- R10: DMA event output k equals external pin k after the two-flop synchronizer, two cycles after the pin changes, and it is never inverted by polarity.
- R11: Each rising edge of a selected level gives exactly one single-cycle pulse. A level that stays high gives no further pulses, and a falling level gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte address within the block |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte enables for writes |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| per_src_i | input | N_PER | Peripheral interrupt levels, synchronous to clk_i |
| ext_pin_i | input | N_EXT | External interrupt pins, asynchronous |
| cpu_irq_o | output | 12 | Edge pulses for INT4 (bit 0) through INT15 (bit 11) |
| dma_evt_o | output | N_EXT | Synchronized, uninverted external pins |

## Verification
The assertions assume three things about the inputs: the peripheral levels are already synchronous to the clock, the read strobe and the write strobe are never asserted together, and the address is stable while a strobe is high. The bench drives every input on the falling clock edge and issues a single strobe per transaction. Peripheral levels and pins change only between bus transactions, so each pulse window has exactly one cause. Sources are held low whenever a select or polarity write could otherwise produce an edge that is not part of the check.

// File: rtl/isel_pkg.sv
package isel_pkg;

   localparam int unsigned BUS_W       = 32;
   localparam int unsigned BE_W        = BUS_W / 8;
   localparam int unsigned SEL_W       = 5;
   localparam int unsigned FLD_PER_REG = 6;
   localparam int unsigned N_MUX_REG   = 2;
   localparam int unsigned N_LINE      = FLD_PER_REG * N_MUX_REG;
   localparam int unsigned SEL_SPAN    = 1 << SEL_W;

   typedef logic [BUS_W-1:0] word_t;
   typedef logic [SEL_W-1:0] sel_t;

   // register slot decoded from the bus address
   typedef enum logic [1:0] {
      SLOT_HI   = 2'd0,
      SLOT_LO   = 2'd1,
      SLOT_POL  = 2'd2,
      SLOT_NONE = 2'd3
   } slot_e;

   // fields are packed in two halves of a word, with one spare bit after the lower half
   function automatic int unsigned fld_lsb(int unsigned f);
      return f * SEL_W + f / (FLD_PER_REG / 2);
   endfunction

   function automatic word_t fld_mask();
      word_t m;
      m = '0;
      for (int unsigned f = 0; f < FLD_PER_REG; f++) begin
         m = m | (word_t'(SEL_SPAN - 1) << fld_lsb(f));
      end
      return m;
   endfunction

   // storage index 0 covers the lower six lines, index 1 the upper six
   function automatic word_t dflt_image(int unsigned r);
      word_t v;
      v = '0;
      for (int unsigned f = 0; f < FLD_PER_REG; f++) begin
         v = v | (word_t'(r * FLD_PER_REG + f) << fld_lsb(f));
      end
      return v;
   endfunction

   function automatic word_t byte_mask(logic [BE_W-1:0] be);
      word_t m;
      for (int unsigned b = 0; b < BE_W; b++) begin
         m[b*8 +: 8] = {8{be[b]}};
      end
      return m;
   endfunction

endpackage

// File: rtl/isel_regs.sv
module isel_regs
   import isel_pkg::*;
#(
   parameter int unsigned N_EXT  = 4,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    wr_i,
   input  logic                    rd_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  word_t                   wdata_i,
   input  logic [BE_W-1:0]         be_i,
   output word_t                   rdata_o,
   output sel_t [N_LINE-1:0]       sel_o,
   output logic [N_EXT-1:0]        pol_o
);

   localparam int unsigned WORD_W   = ADDR_W - 2;
   localparam word_t       MUX_MASK = fld_mask();
   localparam word_t       POL_MASK = word_t'((64'd1 << N_EXT) - 64'd1);

   if (ADDR_W < 4) begin : g_bad_addr
      $error("isel_regs: ADDR_W must cover three words");
   end
   if (N_EXT < 1 || N_EXT > BUS_W) begin : g_bad_ext
      $error("isel_regs: N_EXT out of range");
   end

   slot_e slot;
   word_t bmask;
   word_t mux_q [N_MUX_REG];
   word_t pol_q;
   word_t rd_val;
   word_t rdata_q;

   always_comb begin
      slot = SLOT_NONE;
      if (addr_i[1:0] == 2'b00) begin
         case (addr_i[ADDR_W-1:2])
            WORD_W'(0): slot = SLOT_HI;
            WORD_W'(1): slot = SLOT_LO;
            WORD_W'(2): slot = SLOT_POL;
            default:    slot = SLOT_NONE;
         endcase
      end
   end

   assign bmask = byte_mask(be_i);

   for (genvar r = 0; r < N_MUX_REG; r++) begin : g_mux
      localparam slot_e MY_SLOT = (r == 0) ? SLOT_LO : SLOT_HI;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            mux_q[r] <= dflt_image(r);
         end else if (wr_i && slot == MY_SLOT) begin
            mux_q[r] <= ((mux_q[r] & ~bmask) | (wdata_i & bmask)) & MUX_MASK;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pol_q <= '0;
      end else if (wr_i && slot == SLOT_POL) begin
         pol_q <= ((pol_q & ~bmask) | (wdata_i & bmask)) & POL_MASK;
      end
   end

   always_comb begin
      case (slot)
         SLOT_HI:  rd_val = mux_q[1];
         SLOT_LO:  rd_val = mux_q[0];
         SLOT_POL: rd_val = pol_q;
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_q <= '0;
      end else begin
         rdata_q <= rd_i ? rd_val : '0;
      end
   end

   assign rdata_o = rdata_q;
   assign pol_o   = pol_q[N_EXT-1:0];

   for (genvar i = 0; i < N_LINE; i++) begin : g_sel
      localparam int unsigned R   = i / FLD_PER_REG;
      localparam int unsigned LSB = fld_lsb(i % FLD_PER_REG);
      assign sel_o[i] = mux_q[R][LSB +: SEL_W];
   end

   // R1: read data port idles at zero when no read was issued
   a_r1_idle_read_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(rd_i) |-> (rdata_o == '0));

   // R2: gap bits of a select register never show up on a read
   a_r2_gap_bits_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rd_i && (slot == SLOT_HI || slot == SLOT_LO)) |-> ((rdata_o & ~MUX_MASK) == '0));

   if (N_EXT < BUS_W) begin : g_rsv_chk
      // R4: reserved polarity bits read as zero
      a_r4_pol_reserved_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(rd_i && slot == SLOT_POL) |-> (rdata_o[BUS_W-1:N_EXT] == '0));
   end

endmodule

// File: rtl/isel_ext_front.sv
module isel_ext_front #(
   parameter int unsigned N_EXT       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_EXT-1:0] ext_i,
   input  logic [N_EXT-1:0] pol_i,
   output logic [N_EXT-1:0] adj_o,
   output logic [N_EXT-1:0] dma_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("isel_ext_front: at least two synchronizer stages required");
   end

   logic [N_EXT-1:0] stg_q [SYNC_STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < SYNC_STAGES; s++) begin
            stg_q[s] <= '0;
         end
      end else begin
         stg_q[0] <= ext_i;
         for (int s = 1; s < SYNC_STAGES; s++) begin
            stg_q[s] <= stg_q[s-1];
         end
      end
   end

   // the event path taps the chain before the polarity stage
   assign dma_o = stg_q[SYNC_STAGES-1];
   assign adj_o = stg_q[SYNC_STAGES-1] ^ pol_i;

   // R10: the event output only moves to a value the chain held one cycle earlier
   a_r10_dma_from_chain : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(dma_o) |-> (dma_o == $past(stg_q[SYNC_STAGES-2])));

endmodule

// File: rtl/isel_route.sv
module isel_route
   import isel_pkg::*;
#(
   parameter int unsigned N_SRC = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [N_SRC-1:0]  src_i,
   input  sel_t [N_LINE-1:0] sel_i,
   output logic [N_LINE-1:0] irq_o
);

   if (N_SRC > SEL_SPAN) begin : g_bad_src
      $error("isel_route: more sources than select codes");
   end

   logic [SEL_SPAN-1:0] src_pad;
   logic [N_LINE-1:0]   lvl;
   logic [N_LINE-1:0]   cur_q;
   logic [N_LINE-1:0]   prev_q;

   // codes beyond the implemented sources land on zero padding
   assign src_pad = SEL_SPAN'(src_i);

   for (genvar i = 0; i < N_LINE; i++) begin : g_line
      assign lvl[i] = src_pad[sel_i[i]];

      // R11: a pulse never lasts beyond one cycle
      a_r11_single_pulse : assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_o[i] |=> !irq_o[i]);

      // R6: an unimplemented select code keeps the line level low
      a_r6_oor_quiet : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (sel_i[i] >= SEL_W'(N_SRC)) |=> !cur_q[i]);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cur_q  <= '0;
         prev_q <= '0;
      end else begin
         cur_q  <= lvl;
         prev_q <= cur_q;
      end
   end

   assign irq_o = cur_q & ~prev_q;

endmodule

// File: rtl/irq_selector.sv
module irq_selector
   import isel_pkg::*;
#(
   parameter int unsigned N_PER       = 12,
   parameter int unsigned N_EXT       = 4,
   parameter int unsigned EXT_BASE    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   input  logic [3:0]        bus_be_i,
   output logic [31:0]       bus_rdata_o,
   input  logic [N_PER-1:0]  per_src_i,
   input  logic [N_EXT-1:0]  ext_pin_i,
   output logic [11:0]       cpu_irq_o,
   output logic [N_EXT-1:0]  dma_evt_o
);

   localparam int unsigned N_SRC = N_PER + N_EXT;

   if (EXT_BASE > N_PER) begin : g_bad_base
      $error("irq_selector: external block must start inside the peripheral range");
   end
   if (N_SRC > SEL_SPAN) begin : g_bad_pool
      $error("irq_selector: source pool exceeds select code space");
   end

   sel_t [N_LINE-1:0] sel_w;
   logic [N_EXT-1:0]  pol_w;
   logic [N_EXT-1:0]  adj_w;
   logic [N_SRC-1:0]  src_all;

   isel_regs #(
      .N_EXT  (N_EXT),
      .ADDR_W (ADDR_W)
   ) i_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (bus_wr_i),
      .rd_i    (bus_rd_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .be_i    (bus_be_i),
      .rdata_o (bus_rdata_o),
      .sel_o   (sel_w),
      .pol_o   (pol_w)
   );

   isel_ext_front #(
      .N_EXT       (N_EXT),
      .SYNC_STAGES (SYNC_STAGES)
   ) i_front (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ext_i  (ext_pin_i),
      .pol_i  (pol_w),
      .adj_o  (adj_w),
      .dma_o  (dma_evt_o)
   );

   // pool order: low peripherals, external block, remaining peripherals
   for (genvar k = 0; k < N_SRC; k++) begin : g_pool
      if (k < EXT_BASE) begin : g_per_lo
         assign src_all[k] = per_src_i[k];
      end else if (k < EXT_BASE + N_EXT) begin : g_ext
         assign src_all[k] = adj_w[k-EXT_BASE];
      end else begin : g_per_hi
         assign src_all[k] = per_src_i[k-N_EXT];
      end
   end

   isel_route #(
      .N_SRC (N_SRC)
   ) i_route (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_all),
      .sel_i  (sel_w),
      .irq_o  (cpu_irq_o)
   );

   // R9: a polarity change with a steady synchronized pin moves the adjusted level
   a_r9_pol_moves_level : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((pol_w != $past(pol_w)) && (dma_evt_o == $past(dma_evt_o)))
         |-> ((adj_w ^ $past(adj_w)) == (pol_w ^ $past(pol_w))));

endmodule

// File: tb/test_irq_selector.sv
`timescale 1ns/1ps
module test_irq_selector;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr, rd;
   logic [3:0]  addr;
   logic [31:0] wdata;
   logic [3:0]  be;
   logic [31:0] rdata;
   logic [11:0] per;
   logic [3:0]  ext;
   logic [11:0] irq;
   logic [3:0]  dma;
   int          checks = 0;
   int          errors = 0;
   bit          done   = 1'b0;

   always #2.5 clk = ~clk;

   irq_selector i_irq_selector (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_wr_i    (wr),
      .bus_rd_i    (rd),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_be_i    (be),
      .bus_rdata_o (rdata),
      .per_src_i   (per),
      .ext_pin_i   (ext),
      .cpu_irq_o   (irq),
      .dma_evt_o   (dma)
   );

   // {addr, be, wdata, expected read of the same address}
   localparam int NV = 9;
   localparam logic [71:0] TBL [NV] = '{
      {4'h8, 4'hF, 32'hFFFF_FFFF, 32'h0000_000F},   // R4
      {4'h8, 4'h0, 32'h0000_0000, 32'h0000_000F},   // R5
      {4'h8, 4'h1, 32'hFFFF_FFFA, 32'h0000_000A},   // R4 R5
      {4'h4, 4'hF, 32'hFFFF_FFFF, 32'h7FFF_7FFF},   // R2
      {4'h4, 4'h1, 32'h0000_0000, 32'h7FFF_7F00},   // R5
      {4'h0, 4'hF, 32'h0000_0005, 32'h0000_0005},   // R1
      {4'h0, 4'hC, 32'hFFFF_0000, 32'h7FFF_0005},   // R5
      {4'hC, 4'hF, 32'h1234_5678, 32'h0000_0000},   // R1 unmapped
      {4'h6, 4'hF, 32'h0000_0000, 32'h0000_0000}    // R1 misaligned
   };

   task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [3:0] b, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; be = b; wdata = d;
      @(negedge clk);
      wr = 1'b0; be = 4'h0; wdata = '0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      rd = 1'b1; addr = a;
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   // counts pulses per line over a window and compares with the expected set
   task automatic observe(input logic [11:0] exp, input string tag);
      int          cnt [12];
      logic [11:0] got;
      bit          multi;
      foreach (cnt[j]) cnt[j] = 0;
      repeat (6) begin
         @(negedge clk);
         for (int j = 0; j < 12; j++) if (irq[j]) cnt[j]++;
      end
      multi = 1'b0;
      for (int j = 0; j < 12; j++) begin
         got[j] = (cnt[j] != 0);
         if (cnt[j] > 1) multi = 1'b1;
      end
      check((got == exp) && !multi, tag, {19'd0, multi, got}, {20'd0, exp});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog got %h exp %h", 32'd0, 32'd1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0; be = '0;
      per = '0; ext = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check(irq == 12'h000 && dma == 4'h0, "R3 outputs after reset", {16'd0, dma, irq}, 32'd0);
      check(rdata == 32'h0, "R1 idle read port", rdata, 32'h0);
      rd_reg(4'h0, d); check(d == 32'h2D49_20E6, "R3 default upper selects", d, 32'h2D49_20E6);
      rd_reg(4'h4, d); check(d == 32'h1483_0820, "R3 default lower selects", d, 32'h1483_0820);
      rd_reg(4'h8, d); check(d == 32'h0, "R3 default polarity", d, 32'h0);

      // register table
      for (int v = 0; v < NV; v++) begin
         logic [71:0] e;
         e = TBL[v];
         wr_reg(e[71:68], e[67:64], e[63:32]);
         rd_reg(e[71:68], d);
         check(d == e[31:0], $sformatf("R1 R2 R4 R5 vector %0d", v), d, e[31:0]);
      end
      rd_reg(4'h4, d); check(d == 32'h7FFF_7F00, "R1 misaligned write ignored", d, 32'h7FFF_7F00);
      @(negedge clk);
      check(rdata == 32'h0, "R1 read port clears", rdata, 32'h0);

      // restore defaults
      wr_reg(4'h8, 4'hF, 32'h0);
      wr_reg(4'h0, 4'hF, 32'h2D49_20E6);
      wr_reg(4'h4, 4'hF, 32'h1483_0820);
      observe(12'h000, "R3 restore quiet");

      // peripheral edge: INT4 takes peripheral 0
      @(negedge clk); per[0] = 1'b1;
      @(negedge clk); check(irq == 12'h001, "R7 peripheral latency", {20'd0, irq}, 32'h001);
      @(negedge clk); check(irq == 12'h000, "R11 pulse width", {20'd0, irq}, 32'h000);
      observe(12'h000, "R11 held level no repeat");
      @(negedge clk); per[0] = 1'b0;
      observe(12'h000, "R11 falling level quiet");

      // external pin 4 on INT8 (bit 4)
      @(negedge clk); ext[0] = 1'b1;
      @(negedge clk); check(irq == 12'h000 && dma[0] == 1'b0, "R7 ext cycle1", {16'd0, dma, irq}, 32'h0);
      @(negedge clk); check(dma[0] == 1'b1, "R10 dma latency", {28'd0, dma}, 32'h1);
      check(irq == 12'h000, "R7 ext cycle2", {20'd0, irq}, 32'h0);
      @(negedge clk); check(irq == 12'h010, "R7 ext latency", {20'd0, irq}, 32'h010);
      @(negedge clk); ext[0] = 1'b0;
      observe(12'h000, "R7 falling pin quiet with polarity 0");
      check(dma[0] == 1'b0, "R10 dma follows pin low", {28'd0, dma}, 32'h0);

      // inverted polarity
      wr_reg(4'h8, 4'hF, 32'h1);
      observe(12'h010, "R9 set polarity with pin low");
      @(negedge clk); ext[0] = 1'b1;
      observe(12'h000, "R8 rising pin quiet with polarity 1");
      check(dma[0] == 1'b1, "R10 dma not inverted", {28'd0, dma}, 32'h1);
      @(negedge clk); ext[0] = 1'b0;
      observe(12'h010, "R8 falling pin raises");

      // pin 5 on INT9 (bit 5)
      @(negedge clk); ext[1] = 1'b1;
      observe(12'h020, "R7 rising pin 5");
      wr_reg(4'h8, 4'hF, 32'h3);
      observe(12'h000, "R9 set polarity with pin high quiet");
      wr_reg(4'h8, 4'hF, 32'h1);
      observe(12'h020, "R9 clear polarity with pin high");
      @(negedge clk); ext[1] = 1'b0;
      observe(12'h000, "R7 falling pin 5 quiet");
      wr_reg(4'h8, 4'hF, 32'h0);
      observe(12'h000, "R9 clear polarity with pin low quiet");

      // fan-out: INT4..INT9 and INT10 all on pin 6
      wr_reg(4'h4, 4'hF, 32'h18C6_18C6);
      observe(12'h000, "R6 reselect quiet");
      wr_reg(4'h8, 4'hF, 32'h4);
      observe(12'h07F, "R9 polarity edge on every mapped line");
      wr_reg(4'h8, 4'hF, 32'h0);
      observe(12'h000, "R9 polarity back quiet");

      // index space and unimplemented codes
      wr_reg(4'h4, 4'hF, 32'h0207_3D03);
      wr_reg(4'h0, 4'hF, 32'h7FFF_7FF0);
      observe(12'h000, "R6 remap quiet");
      @(negedge clk); per[3] = 1'b1;
      observe(12'h001, "R6 index 3 is peripheral 3");
      @(negedge clk); per[4] = 1'b1;
      observe(12'h002, "R6 index 8 is peripheral 4");
      @(negedge clk); per[11] = 1'b1;
      observe(12'h004, "R6 index 15 is peripheral 11");
      @(negedge clk); ext[3] = 1'b1;
      observe(12'h008, "R6 index 7 is pin 7");
      @(negedge clk); per[0] = 1'b1;
      observe(12'h020, "R6 index 0 is peripheral 0");
      @(negedge clk); per = '1; ext = '1;
      observe(12'h000, "R6 codes 16 and up stay low");
      @(negedge clk); per = '0; ext = '0;
      observe(12'h000, "R11 all falling quiet");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule